// File: doc/BRIEF.md
# DRAM Read/Write Turnaround Scheduler

This block is the mode controller that sits at the centre of a DRAM command multiplexer. Bank machines report whether they hold reads or writes, and the refresh engine raises a request when a refresh is due. The scheduler decides each cycle whether the shared command bus serves reads, serves writes, sits in a bus turnaround or issues a refresh. Its grant strobes tell the request chooser which class of request may go out.

Each direction has its own time budget. The bus stays with reads while reads are pending and their budget lasts. It changes direction when the other side has work and either the budget is spent or the current side has gone quiet. Changing direction passes through a fixed idle gap: read-to-write uses a configurable gap, and write-to-read uses the write-to-read recovery time. A refresh takes priority. The bus finishes the current direction cleanly, issues one refresh, and resumes in read mode.

For each phase of the multi-phase command interface the block drives a steering select code and the command code on (cas_n, ras_n, we_n). It also drives read and write data-enable strobes, placed on the configured phase and delayed by the configured latency.

Top module: `dram_turn_sched`

## Requirements
- R1: During and right after reset the mode is read (code 0), no grant is active, every phase carries the idle command 3'b111, and both data-enable buses are zero.
- R2: Mode codes are read=0, write=1, turnaround=2, refresh=3. In read mode the read grant follows the read-pending input and no write grant is given. In write mode the write grant follows the write-pending input and no read grant is given. In turnaround and refresh modes neither is granted.
- R3: In read mode, with writes pending, the scheduler leaves for the write side when no reads are pending or when READ_BUDGET (32) cycles have been spent in read mode. With both sides pending from reset, exactly 32 consecutive read grants are given.
- R4: The write side mirrors R3 with WRITE_BUDGET (16) cycles, so 16 consecutive write grants are given when both sides stay pending.
- R5: Between read mode and write mode there are exactly RTW_GAP (2) turnaround cycles.
- R6: Between write mode and read mode there are exactly T_WTR-1 (3) turnaround cycles, so a write granted in the last write cycle is followed by the first read grant exactly T_WTR (4) cycles later.
- R7: An expired budget does not force a switch while the other side is idle. The mode holds and keeps granting, and it switches at the end of the first cycle in which the other side is pending.
- R8: A refresh request seen in read mode gives refresh mode with a one-cycle refresh grant in the next cycle, then read mode.
- R9: A refresh request seen in write mode first passes through the write-to-read turnaround, then gives refresh mode with a refresh grant, then read mode.
- R10: Each phase drives a 3-bit {cas_n, ras_n, we_n} field at bits [3p+2:3p]. A read grant puts 3'b011 on phase RD_PHASE (1), a write grant puts 3'b010 on phase WR_PHASE (0), and a refresh grant puts 3'b001 on phase 0. All other phases carry 3'b111.
- R11: Each phase has a 2-bit select field at bits [2p+1:2p]: none=0, command=1, request=2, refresh=3. In read or write mode the data phase of that direction gets request and the other phases get command. Turnaround gives command on all phases. Refresh mode gives refresh on phase 0 and none elsewhere.
- R12: The read data enable rises on bit RD_PHASE exactly RD_LAT (3) cycles after a read grant. The write data enable rises on bit WR_PHASE exactly WR_LAT (1) cycle after a write grant. All other bits stay zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdPending | input | 1 | Some bank machine holds a read |
| wrPending | input | 1 | Some bank machine holds a write |
| refreshReq | input | 1 | Refresh is due |
| mode | output | 2 | Current bus mode (read, write, turnaround, refresh) |
| rdGrant | output | 1 | A read may be issued this cycle |
| wrGrant | output | 1 | A write may be issued this cycle |
| refGrant | output | 1 | The refresh is issued this cycle |
| phaseSel | output | 2*NPHASES | Per-phase steering select codes |
| phaseCmd | output | 3*NPHASES | Per-phase {cas_n, ras_n, we_n} |
| rdDataEn | output | NPHASES | Read data enable per phase |
| wrDataEn | output | NPHASES | Write data enable per phase |

## Verification
The bench measures the run lengths that matter directly: consecutive read grants, consecutive write grants, and the two turnaround gaps. An off-by-one budget or gap counter therefore shows up as a run of 31 or 33, or as a gap that is short by one cycle and would break write-to-read recovery. It holds one side idle after its budget has expired, which catches a design that leaves a direction needlessly or fails to switch at once when work appears. It also raises refresh in both modes, which catches a refresh taken straight out of write mode without the recovery gap. It checks the data-enable latencies and the phase codes every cycle, so a strobe on the wrong phase or one cycle off is caught.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic [1:0] {
    MODE_READ    = 2'd0,
    MODE_WRITE   = 2'd1,
    MODE_TURN    = 2'd2,
    MODE_REFRESH = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SEL_NONE    = 2'd0,
    SEL_CMD     = 2'd1,
    SEL_REQ     = 2'd2,
    SEL_REFRESH = 2'd3
  } sel_e;

  // {cas_n, ras_n, we_n}
  localparam logic [2:0] CMD_IDLE    = 3'b111;
  localparam logic [2:0] CMD_READ    = 3'b011;
  localparam logic [2:0] CMD_WRITE   = 3'b010;
  localparam logic [2:0] CMD_REFRESH = 3'b001;

  typedef struct packed {
    logic  rdGrant;
    logic  wrGrant;
    logic  refGrant;
    mode_e mode;
  } strobe_t;

endpackage

// File: rtl/sched_delay.sv
module sched_delay #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [DEPTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[DEPTH-1];

endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
#(
  parameter int READ_BUDGET  = 32,
  parameter int WRITE_BUDGET = 16,
  parameter int T_WTR        = 4,
  parameter int RTW_GAP      = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rdPending,
  input  logic    wrPending,
  input  logic    refreshReq,
  output strobe_t strobe
);

  localparam int MaxBudget = (READ_BUDGET > WRITE_BUDGET) ? READ_BUDGET : WRITE_BUDGET;
  localparam int BudgetW   = $clog2(MaxBudget + 1);
  localparam int MaxGap    = (T_WTR > RTW_GAP) ? T_WTR : RTW_GAP;
  localparam int GapW      = $clog2(MaxGap + 1);
  localparam int AgeMax    = MaxGap + 1;
  localparam int AgeW      = $clog2(AgeMax + 1);

  typedef enum logic [2:0] {ST_READ, ST_RTW, ST_WRITE, ST_WTR, ST_REF} state_e;

  state_e             state, nextState;
  logic [BudgetW-1:0] budgetCnt, budgetLimit;
  logic               budgetDone;
  logic [GapW-1:0]    gapCnt;

  always_comb begin
    budgetLimit = (state == ST_WRITE) ? BudgetW'(WRITE_BUDGET - 1) : BudgetW'(READ_BUDGET - 1);
    budgetDone  = (budgetCnt == budgetLimit);
    nextState   = state;
    case (state)
      ST_READ: begin
        if (refreshReq) nextState = ST_REF;
        else if (wrPending && (!rdPending || budgetDone)) nextState = ST_RTW;
      end
      ST_RTW:   if (gapCnt == '0) nextState = ST_WRITE;
      ST_WRITE: begin
        if (refreshReq || (rdPending && (!wrPending || budgetDone))) nextState = ST_WTR;
      end
      ST_WTR:   if (gapCnt == '0) nextState = refreshReq ? ST_REF : ST_READ;
      ST_REF:   nextState = ST_READ;
      default:  nextState = ST_READ;
    endcase
  end

  always_comb begin
    strobe.rdGrant  = (state == ST_READ) && rdPending;
    strobe.wrGrant  = (state == ST_WRITE) && wrPending;
    strobe.refGrant = (state == ST_REF);
    case (state)
      ST_READ:  strobe.mode = MODE_READ;
      ST_WRITE: strobe.mode = MODE_WRITE;
      ST_REF:   strobe.mode = MODE_REFRESH;
      default:  strobe.mode = MODE_TURN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_READ;
      budgetCnt <= '0;
      gapCnt    <= '0;
    end else begin
      state <= nextState;
      if (nextState != state) budgetCnt <= '0;
      else if (!budgetDone)   budgetCnt <= budgetCnt + 1'b1;
      if (nextState == ST_RTW && state != ST_RTW)      gapCnt <= GapW'(RTW_GAP - 1);
      else if (nextState == ST_WTR && state != ST_WTR) gapCnt <= GapW'(T_WTR - 2);
      else if (gapCnt != '0)                           gapCnt <= gapCnt - 1'b1;
    end
  end

  // Cycle counters since the last grant of each direction, for the gap checks.
  logic [AgeW-1:0] rdAge, wrAge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdAge <= AgeW'(AgeMax);
      wrAge <= AgeW'(AgeMax);
    end else begin
      if (strobe.rdGrant)             rdAge <= AgeW'(1);
      else if (rdAge != AgeW'(AgeMax)) rdAge <= rdAge + 1'b1;
      if (strobe.wrGrant)             wrAge <= AgeW'(1);
      else if (wrAge != AgeW'(AgeMax)) wrAge <= wrAge + 1'b1;
    end
  end

  AST_WTR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.rdGrant |-> wrAge >= AgeW'(T_WTR)); // R6
  AST_RTW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrGrant |-> rdAge >= AgeW'(RTW_GAP + 1)); // R5
  AST_REF_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.refGrant |=> strobe.mode == MODE_READ); // R8

endmodule

// File: rtl/sched_datapath.sv
module sched_datapath
  import sched_pkg::*;
#(
  parameter int NPHASES  = 2,
  parameter int RD_PHASE = 1,
  parameter int WR_PHASE = 0,
  parameter int RD_LAT   = 3,
  parameter int WR_LAT   = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  strobe_t                strobe,
  output logic [2*NPHASES-1:0]   phaseSel,
  output logic [3*NPHASES-1:0]   phaseCmd,
  output logic [NPHASES-1:0]     rdDataEn,
  output logic [NPHASES-1:0]     wrDataEn
);

  always_comb begin
    for (int p = 0; p < NPHASES; p++) begin
      case (strobe.mode)
        MODE_READ:    phaseSel[2*p +: 2] = (p == RD_PHASE) ? SEL_REQ : SEL_CMD;
        MODE_WRITE:   phaseSel[2*p +: 2] = (p == WR_PHASE) ? SEL_REQ : SEL_CMD;
        MODE_REFRESH: phaseSel[2*p +: 2] = (p == 0) ? SEL_REFRESH : SEL_NONE;
        default:      phaseSel[2*p +: 2] = SEL_CMD;
      endcase
      if (strobe.rdGrant && p == RD_PHASE)       phaseCmd[3*p +: 3] = CMD_READ;
      else if (strobe.wrGrant && p == WR_PHASE)  phaseCmd[3*p +: 3] = CMD_WRITE;
      else if (strobe.refGrant && p == 0)        phaseCmd[3*p +: 3] = CMD_REFRESH;
      else                                       phaseCmd[3*p +: 3] = CMD_IDLE;
    end
  end

  logic rdLate, wrLate;

  sched_delay #(.DEPTH(RD_LAT)) u_rdDelay (
    .clk(clk), .rst_n(rst_n), .din(strobe.rdGrant), .dout(rdLate)
  );
  sched_delay #(.DEPTH(WR_LAT)) u_wrDelay (
    .clk(clk), .rst_n(rst_n), .din(strobe.wrGrant), .dout(wrLate)
  );

  always_comb begin
    rdDataEn           = '0;
    rdDataEn[RD_PHASE] = rdLate;
    wrDataEn           = '0;
    wrDataEn[WR_PHASE] = wrLate;
  end

  AST_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.rdGrant || strobe.wrGrant || strobe.refGrant) |-> phaseCmd == {NPHASES{CMD_IDLE}}); // R10

endmodule

// File: rtl/dram_turn_sched.sv
module dram_turn_sched
  import sched_pkg::*;
#(
  parameter int READ_BUDGET  = 32,
  parameter int WRITE_BUDGET = 16,
  parameter int T_WTR        = 4,
  parameter int RTW_GAP      = 2,
  parameter int NPHASES      = 2,
  parameter int RD_PHASE     = 1,
  parameter int WR_PHASE     = 0,
  parameter int RD_LAT       = 3,
  parameter int WR_LAT       = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rdPending,
  input  logic                 wrPending,
  input  logic                 refreshReq,
  output logic [1:0]           mode,
  output logic                 rdGrant,
  output logic                 wrGrant,
  output logic                 refGrant,
  output logic [2*NPHASES-1:0] phaseSel,
  output logic [3*NPHASES-1:0] phaseCmd,
  output logic [NPHASES-1:0]   rdDataEn,
  output logic [NPHASES-1:0]   wrDataEn
);

  strobe_t strobe;

  sched_ctrl #(
    .READ_BUDGET(READ_BUDGET), .WRITE_BUDGET(WRITE_BUDGET),
    .T_WTR(T_WTR), .RTW_GAP(RTW_GAP)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rdPending(rdPending), .wrPending(wrPending),
    .refreshReq(refreshReq), .strobe(strobe)
  );

  sched_datapath #(
    .NPHASES(NPHASES), .RD_PHASE(RD_PHASE), .WR_PHASE(WR_PHASE),
    .RD_LAT(RD_LAT), .WR_LAT(WR_LAT)
  ) u_datapath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .phaseSel(phaseSel),
    .phaseCmd(phaseCmd), .rdDataEn(rdDataEn), .wrDataEn(wrDataEn)
  );

  assign mode     = strobe.mode;
  assign rdGrant  = strobe.rdGrant;
  assign wrGrant  = strobe.wrGrant;
  assign refGrant = strobe.refGrant;

endmodule

// File: tb/dram_turn_sched_tb.sv
module dram_turn_sched_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rdPending = 1'b0, wrPending = 1'b0, refreshReq = 1'b0;
  logic [1:0] mode;
  logic       rdGrant, wrGrant, refGrant;
  logic [3:0] phaseSel;
  logic [5:0] phaseCmd;
  logic [1:0] rdDataEn, wrDataEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dram_turn_sched #(
    .READ_BUDGET(32), .WRITE_BUDGET(16), .T_WTR(4), .RTW_GAP(2),
    .NPHASES(2), .RD_PHASE(1), .WR_PHASE(0), .RD_LAT(3), .WR_LAT(1)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .rdPending(rdPending), .wrPending(wrPending),
    .refreshReq(refreshReq), .mode(mode), .rdGrant(rdGrant), .wrGrant(wrGrant),
    .refGrant(refGrant), .phaseSel(phaseSel), .phaseCmd(phaseCmd),
    .rdDataEn(rdDataEn), .wrDataEn(wrDataEn)
  );

  // {rd, wr, ref, mode[1:0], rdG, wrG, refG, rdEn, wrEn}
  localparam logic [9:0] VEC [25] = '{
    10'b000_00_000_00, 10'b100_00_100_00, 10'b100_00_100_00, 10'b010_00_000_00,
    10'b010_10_000_10, 10'b010_10_000_10, 10'b010_01_010_00, 10'b110_01_010_01,
    10'b100_01_000_01, 10'b100_10_000_00, 10'b100_10_000_00, 10'b100_10_000_00,
    10'b100_00_100_00, 10'b001_00_000_00, 10'b000_11_001_00, 10'b000_00_000_10,
    10'b010_00_000_00, 10'b010_10_000_00, 10'b010_10_000_00, 10'b011_01_010_00,
    10'b001_10_000_01, 10'b001_10_000_00, 10'b001_10_000_00, 10'b000_11_001_00,
    10'b000_00_000_00
  };

  function automatic string rowTag(int i);
    if (i <= 2)  return "R2 idle/read grant";
    if (i <= 6)  return "R5 read-to-write";
    if (i == 7)  return "R2 write grant";
    if (i <= 12) return "R6 write-to-read";
    if (i <= 15) return "R8 refresh from read";
    if (i <= 18) return "R5 second read-to-write";
    return "R9 refresh from write";
  endfunction

  function automatic logic [5:0] expCmd(logic [2:0] g);
    case (g)
      3'b100:  return 6'b011_111;
      3'b010:  return 6'b111_010;
      3'b001:  return 6'b111_001;
      default: return 6'b111_111;
    endcase
  endfunction

  function automatic logic [3:0] expSel(logic [1:0] m);
    case (m)
      2'd0:    return 4'b10_01;
      2'd1:    return 4'b01_10;
      2'd2:    return 4'b01_01;
      default: return 4'b00_11;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic doReset(input logic r, input logic w);
    @(negedge clk);
    rst_n = 1'b0; rdPending = 1'b0; wrPending = 1'b0; refreshReq = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; rdPending = r; wrPending = w;
    #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #2;
    chk("R1 mode/grants in reset", {mode, rdGrant, wrGrant, refGrant}, 5'b00_000);
    chk("R1 commands idle", phaseCmd, 6'h3f);
    chk("R1 data enables", {rdDataEn, wrDataEn}, 4'b0000);
    chk("R11 select in reset", phaseSel, expSel(2'd0));
    @(negedge clk);
    rst_n = 1'b1;

    // Vector table
    for (int i = 0; i < 25; i++) begin
      logic [9:0] v;
      v = VEC[i];
      @(negedge clk);
      rdPending = v[9]; wrPending = v[8]; refreshReq = v[7];
      #2;
      chk(rowTag(i), {mode, rdGrant, wrGrant, refGrant}, v[6:2]);
      chk("R12 read data enable", rdDataEn, v[1] ? 2'b10 : 2'b00);
      chk("R12 write data enable", wrDataEn, v[0] ? 2'b01 : 2'b00);
      chk("R10 phase commands", phaseCmd, expCmd(v[4:2]));
      chk("R11 phase selects", phaseSel, expSel(v[6:5]));
    end

    // R3/R4/R5/R6: both sides pending from reset
    begin
      int n;
      doReset(1'b1, 1'b1);
      n = 0;
      while (rdGrant && n < 100) begin n++; step(); end
      chk("R3 read run length", n, 32);
      n = 0;
      while (mode == 2'd2 && n < 100) begin n++; step(); end
      chk("R5 read-to-write gap", n, 2);
      n = 0;
      while (wrGrant && n < 100) begin n++; step(); end
      chk("R4 write run length", n, 16);
      n = 0;
      while (mode == 2'd2 && n < 100) begin n++; step(); end
      chk("R6 write-to-read gap", n, 3);
      chk("R6 first read after gap", {mode, rdGrant}, 3'b00_1);
    end

    // R7: expired budget, other side idle
    begin
      int bad;
      doReset(1'b1, 1'b0);
      bad = 0;
      for (int k = 0; k < 40; k++) begin
        if (!rdGrant || mode != 2'd0) bad++;
        step();
      end
      chk("R7 holds read past budget", bad, 0);
      @(negedge clk);
      wrPending = 1'b1;
      #2;
      chk("R7 read granted in switch cycle", {mode, rdGrant}, 3'b00_1);
      step();
      chk("R7 switches at once", mode, 2'd2);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule